// File: doc/BRIEF.md
# Asynchronous SRAM Strobe Sequencer

This block sits between a clocked host and an external static RAM that has no clock of its own. A host request is a read or a write with an address and, for writes, a data word. The request is offered with a valid signal and taken when ready is high. The sequencer then holds the address steady. It drives the three active-low memory strobes (chip select, output enable, write enable) in a fixed order. Between each pair of edges it waits a programmed number of clocks. At the end it returns a single-cycle done pulse, plus the read word when the request was a read.

The memory has one shared set of data pins. The block does not place a tri-state buffer itself. It presents outgoing data, a drive-enable that a pad cell uses, and the incoming pin value. The drive-enable is only high when the memory's output is off, and a guard interval surrounds every change of bus direction. Between any two memory cycles, chip select goes high and the bus is released for at least one clock.

Top module: `sram_seq_top`

## Requirements
- R1: During and right after reset, chip select, output enable and write enable are all high (inactive), the drive-enable is low, done is low and ready is high.
- R2: A read runs as follows. Chip select goes low with output enable still high for TURN_WAIT clocks. Then output enable goes low for ACC_WAIT clocks. Write enable stays high for the whole read.
- R3: Read data is sampled from the pins on the clock edge that ends the output-enable window. It appears on rdData in the same cycle as done.
- R4: A write runs as follows. The address is first presented for one clock with chip select high. Then chip select is low for SETUP_WAIT clocks before write enable falls.
- R5: Once write enable is low, the bus stays released for TURN_WAIT clocks. The block then drives the write data for WRITE_WAIT clocks. Write enable then rises while chip select stays low and the data is held for one more clock.
- R6: The drive-enable is never high while output enable is low.
- R7: done lasts exactly one clock. In that clock all three strobes are high and the bus is released. The cycle after done is also idle, so every memory cycle is separated by at least one such gap.
- R8: ready is high only while idle. A request held valid during a cycle is not taken until the block returns to idle.
- R9: Output enable and write enable are never low at the same time.
- R10: The memory address output equals the accepted request address for every clock of the memory cycle.
- R11: All four wait counts are parameters in clocks with a minimum of one; the sequence lengths in R2 and R5 scale with them exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Host request valid |
| reqReady | output | 1 | Block idle and able to take a request |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W | Request address |
| reqWdata | input | DATA_W | Write data |
| done | output | 1 | One-cycle completion pulse |
| rdData | output | DATA_W | Read result, valid with done |
| sramAddr | output | ADDR_W | Address to memory |
| sramCsN | output | 1 | Chip select, active low |
| sramOeN | output | 1 | Output enable, active low |
| sramWeN | output | 1 | Write enable, active low |
| sramDout | output | DATA_W | Data toward the shared pins |
| sramDoe | output | 1 | Pad drive enable for sramDout |
| sramDin | input | DATA_W | Value seen on the shared pins |

## Verification
The hardest case to reach from the ports is a host that keeps its request valid through a whole memory cycle. Ready must stay low for every clock of that cycle. The held request must be taken only in the idle clock after the gap, not as a back-to-back cycle. The bench holds valid high across entire reads and writes and compares the full strobe vector against a queued reference timeline every clock, so an early acceptance shows up as a wrong vector. A memory model in the bench commits data only when write enable rises, and otherwise returns a marker word. Because the reference timeline is checked each clock, a missed hold cycle or a capture on the wrong edge appears as wrong read-back data.

// File: rtl/sram_seq_pkg.sv
package sram_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_SEL,
    ST_RD_ACC,
    ST_WR_ADDR,
    ST_WR_SETUP,
    ST_WR_TURN,
    ST_WR_DATA,
    ST_WR_HOLD
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic accept;   // latch request
    logic capture;  // sample read pins
    logic drive;    // enable write data onto pins
    logic csN;
    logic oeN;
    logic weN;
  } seqStrobe_t;

endpackage

// File: rtl/sram_seq_ctrl.sv
module sram_seq_ctrl
  import sram_seq_pkg::*;
#(
  parameter int ACC_WAIT   = 3,
  parameter int SETUP_WAIT = 2,
  parameter int TURN_WAIT  = 1,
  parameter int WRITE_WAIT = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       reqWrite,
  output logic       reqReady,
  output logic       done,
  output seqStrobe_t strobe
);

  localparam int MAX_AB  = (ACC_WAIT > SETUP_WAIT) ? ACC_WAIT : SETUP_WAIT;
  localparam int MAX_CD  = (TURN_WAIT > WRITE_WAIT) ? TURN_WAIT : WRITE_WAIT;
  localparam int MAX_W   = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
  localparam int CNT_W   = (MAX_W < 2) ? 1 : $clog2(MAX_W);

  localparam logic [CNT_W-1:0] LD_ACC   = CNT_W'(ACC_WAIT - 1);
  localparam logic [CNT_W-1:0] LD_SETUP = CNT_W'(SETUP_WAIT - 1);
  localparam logic [CNT_W-1:0] LD_TURN  = CNT_W'(TURN_WAIT - 1);
  localparam logic [CNT_W-1:0] LD_WRITE = CNT_W'(WRITE_WAIT - 1);

  seqState_t        state, stateNxt;
  logic [CNT_W-1:0] waitCnt, waitCntNxt;
  logic             doneQ, doneNxt;
  logic             cntZero;

  assign cntZero = (waitCnt == '0);

  always_comb begin
    stateNxt   = state;
    waitCntNxt = cntZero ? waitCnt : waitCnt - 1'b1;
    doneNxt    = 1'b0;
    unique case (state)
      ST_IDLE: if (reqValid && !doneQ) begin
        if (reqWrite) begin
          stateNxt   = ST_WR_ADDR;
          waitCntNxt = '0;
        end else begin
          stateNxt   = ST_RD_SEL;
          waitCntNxt = LD_TURN;
        end
      end
      ST_RD_SEL: if (cntZero) begin
        stateNxt   = ST_RD_ACC;
        waitCntNxt = LD_ACC;
      end
      ST_RD_ACC: if (cntZero) begin
        stateNxt = ST_IDLE;
        doneNxt  = 1'b1;
      end
      ST_WR_ADDR: begin
        stateNxt   = ST_WR_SETUP;
        waitCntNxt = LD_SETUP;
      end
      ST_WR_SETUP: if (cntZero) begin
        stateNxt   = ST_WR_TURN;
        waitCntNxt = LD_TURN;
      end
      ST_WR_TURN: if (cntZero) begin
        stateNxt   = ST_WR_DATA;
        waitCntNxt = LD_WRITE;
      end
      ST_WR_DATA: if (cntZero) stateNxt = ST_WR_HOLD;
      ST_WR_HOLD: begin
        stateNxt = ST_IDLE;
        doneNxt  = 1'b1;
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      waitCnt <= '0;
      doneQ   <= 1'b0;
    end else begin
      state   <= stateNxt;
      waitCnt <= waitCntNxt;
      doneQ   <= doneNxt;
    end
  end

  // doneQ marks the completion clock, spent idle with strobes high
  assign done     = doneQ;
  assign reqReady = (state == ST_IDLE) && !doneQ;

  always_comb begin
    strobe         = '0;
    strobe.csN     = 1'b1;
    strobe.oeN     = 1'b1;
    strobe.weN     = 1'b1;
    strobe.accept  = (state == ST_IDLE) && !doneQ && reqValid;
    strobe.capture = (state == ST_RD_ACC) && cntZero;
    unique case (state)
      ST_RD_SEL:   strobe.csN = 1'b0;
      ST_RD_ACC:   begin strobe.csN = 1'b0; strobe.oeN = 1'b0; end
      ST_WR_SETUP: strobe.csN = 1'b0;
      ST_WR_TURN:  begin strobe.csN = 1'b0; strobe.weN = 1'b0; end
      ST_WR_DATA:  begin strobe.csN = 1'b0; strobe.weN = 1'b0; strobe.drive = 1'b1; end
      ST_WR_HOLD:  begin strobe.csN = 1'b0; strobe.drive = 1'b1; end
      default:     ;
    endcase
  end

endmodule

// File: rtl/sram_seq_dpath.sv
module sram_seq_dpath
  import sram_seq_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] sramDin,
  output logic [ADDR_W-1:0] sramAddr,
  output logic [DATA_W-1:0] sramDout,
  output logic              sramDoe,
  output logic [DATA_W-1:0] rdData
);

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ;
  logic [DATA_W-1:0] rdQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ  <= '0;
      wdataQ <= '0;
      rdQ    <= '0;
    end else begin
      if (strobe.accept) begin
        addrQ  <= reqAddr;
        wdataQ <= reqWdata;
      end
      if (strobe.capture) rdQ <= sramDin;
    end
  end

  assign sramAddr = addrQ;
  assign sramDout = wdataQ;
  assign sramDoe  = strobe.drive;
  assign rdData   = rdQ;

endmodule

// File: rtl/sram_seq_top.sv
module sram_seq_top
  import sram_seq_pkg::*;
#(
  parameter int ADDR_W     = 10,
  parameter int DATA_W     = 16,
  parameter int ACC_WAIT   = 3,
  parameter int SETUP_WAIT = 2,
  parameter int TURN_WAIT  = 1,
  parameter int WRITE_WAIT = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              done,
  output logic [DATA_W-1:0] rdData,
  output logic [ADDR_W-1:0] sramAddr,
  output logic              sramCsN,
  output logic              sramOeN,
  output logic              sramWeN,
  output logic [DATA_W-1:0] sramDout,
  output logic              sramDoe,
  input  logic [DATA_W-1:0] sramDin
);

  seqStrobe_t strobe;

  sram_seq_ctrl #(
    .ACC_WAIT(ACC_WAIT), .SETUP_WAIT(SETUP_WAIT),
    .TURN_WAIT(TURN_WAIT), .WRITE_WAIT(WRITE_WAIT)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqReady(reqReady), .done(done), .strobe(strobe)
  );

  sram_seq_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .sramDin(sramDin), .sramAddr(sramAddr),
    .sramDout(sramDout), .sramDoe(sramDoe), .rdData(rdData)
  );

  assign sramCsN = strobe.csN;
  assign sramOeN = strobe.oeN;
  assign sramWeN = strobe.weN;

endmodule

// File: rtl/sram_seq_chk.sv
module sram_seq_chk (
  input logic clk,
  input logic rstN,
  input logic reqReady,
  input logic done,
  input logic sramCsN,
  input logic sramOeN,
  input logic sramWeN,
  input logic sramDoe
);

  a_r6_no_contention: assert property (@(posedge clk) disable iff (!rstN)
    sramDoe |-> sramOeN);

  a_r9_oe_we_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(!sramOeN && !sramWeN));

  a_r7_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  a_r7_done_quiet: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (sramCsN && sramOeN && sramWeN && !sramDoe));

  a_r8_ready_quiet: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (sramCsN && sramOeN && sramWeN && !done));

  a_r4_we_after_cs: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sramWeN) |-> $past(!sramCsN));

  a_r2_oe_after_cs: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sramOeN) |-> $past(!sramCsN));

  a_r5_drive_after_we: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sramDoe) |-> (!sramWeN && $past(!sramWeN)));

endmodule

bind sram_seq_top sram_seq_chk u_chk (
  .clk(clk), .rstN(rstN), .reqReady(reqReady), .done(done),
  .sramCsN(sramCsN), .sramOeN(sramOeN), .sramWeN(sramWeN), .sramDoe(sramDoe)
);

// File: tb/sram_seq_top_bench.sv
module sram_seq_top_bench;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 10;
  localparam int DW = 16;
  localparam int ACC = 3;
  localparam int SETUP = 2;
  localparam int TURN = 2;
  localparam int WRITE = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic reqWrite = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic [DW-1:0] reqWdata = '0;
  logic reqReady, done, sramCsN, sramOeN, sramWeN, sramDoe;
  logic [DW-1:0] rdData, sramDout, sramDin;
  logic [AW-1:0] sramAddr;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sram_seq_top #(
    .ADDR_W(AW), .DATA_W(DW), .ACC_WAIT(ACC), .SETUP_WAIT(SETUP),
    .TURN_WAIT(TURN), .WRITE_WAIT(WRITE)
  ) u_sram_seq_top (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .done(done), .rdData(rdData), .sramAddr(sramAddr), .sramCsN(sramCsN),
    .sramOeN(sramOeN), .sramWeN(sramWeN), .sramDout(sramDout),
    .sramDoe(sramDoe), .sramDin(sramDin)
  );

  // memory model: outputs only when selected and reading, commits on write-enable rise
  logic [DW-1:0] mem [1024];
  logic [DW-1:0] refMem [1024];
  logic prevWe = 1'b1;
  assign sramDin = (!sramCsN && !sramOeN && sramWeN) ? mem[sramAddr] : 16'hDEAD;

  always @(negedge clk) begin
    if (!prevWe && sramWeN && !sramCsN && sramDoe) mem[sramAddr] = sramDout;
    prevWe = sramWeN;
  end

  // vector order: ready, done, csN, oeN, weN, doe
  logic [5:0] expQ [$];
  string tagQ [$];

  function automatic logic [5:0] obs();
    return {reqReady, done, sramCsN, sramOeN, sramWeN, sramDoe};
  endfunction

  task automatic check(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic push(logic [5:0] v, string tag, int n);
    for (int i = 0; i < n; i++) begin
      expQ.push_back(v);
      tagQ.push_back(tag);
    end
  endtask

  task automatic runOp(bit wr, logic [AW-1:0] a, logic [DW-1:0] d, bit hold);
    logic [5:0] e;
    string t;
    @(negedge clk);
    check(obs() == 6'b101110, "R8", "idle vector before request", obs(), 6'b101110);
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqWdata = d;
    if (wr) begin
      push(6'b001110, "R4", 1);
      push(6'b000110, "R4", SETUP);
      push(6'b000100, "R5", TURN);
      push(6'b000101, "R5", WRITE);
      push(6'b000111, "R5", 1);
    end else begin
      push(6'b000110, "R2", TURN);
      push(6'b000010, "R2", ACC);
    end
    push(6'b011110, "R7", 1);
    push(6'b101110, "R7", 1);
    while (expQ.size() > 0) begin
      @(negedge clk);
      e = expQ.pop_front();
      t = tagQ.pop_front();
      if (!hold) reqValid = 1'b0;
      check(obs() == e, t, wr ? "write strobe vector" : "read strobe vector", obs(), e);
      if (e[4]) begin
        reqValid = 1'b0;
        if (!wr) check(rdData == refMem[a], "R3", "read data at done", rdData, refMem[a]);
      end else if (!e[5]) begin
        check(sramAddr == a, "R10", "address held", sramAddr, a);
        if (e[0]) check(sramDout == d, "R5", "write data on pins", sramDout, d);
      end
    end
    if (wr) refMem[a] = d;
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) begin
      mem[i] = 16'(i * 3 + 1);
      refMem[i] = 16'(i * 3 + 1);
    end
    repeat (3) @(negedge clk);
    check(obs() == 6'b101110, "R1", "vector in reset", obs(), 6'b101110);
    rstN = 1'b1;
    @(negedge clk);
    check(obs() == 6'b101110, "R1", "vector after reset", obs(), 6'b101110);
    // R2 R3: read of preloaded pattern
    runOp(1'b0, 10'd77, 16'h0, 1'b0);
    // R4 R5: write then read back
    runOp(1'b1, 10'd5, 16'hA5A5, 1'b0);
    runOp(1'b0, 10'd5, 16'h0, 1'b0);
    // boundaries of the address range
    runOp(1'b1, 10'd0, 16'h1234, 1'b0);
    runOp(1'b1, 10'd1023, 16'hFFFF, 1'b0);
    runOp(1'b0, 10'd1023, 16'h0, 1'b0);
    runOp(1'b0, 10'd0, 16'h0, 1'b0);
    // R8: request held valid through whole cycles
    runOp(1'b1, 10'd300, 16'h5A5A, 1'b1);
    runOp(1'b0, 10'd300, 16'h0, 1'b1);
    runOp(1'b1, 10'd300, 16'h0F0F, 1'b1);
    runOp(1'b0, 10'd300, 16'h0, 1'b0);
    // R11: overwrite with zero data, alternate patterns
    runOp(1'b1, 10'd512, 16'h0000, 1'b0);
    runOp(1'b0, 10'd512, 16'h0, 1'b1);
    runOp(1'b0, 10'd513, 16'h0, 1'b0);
    // R6 R9 checked every clock by the strobe vector above
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule